// File: doc/BRIEF.md
# Software Interrupt Pending Register with Change Detection

This block keeps a word of software-raised interrupt bits. Software reaches it through three command strobes that share one wide operand bus. The first strobe ORs bits into the word, the second strips bits out of it, and the third loads it outright. Only the low word of the operand takes part; the upper half is discarded for every command.

After each command the block compares the new word with the old one. When the word really moves, it raises a one-cycle "changed" indication. When that happens while the global interrupt enable is high, it also raises a one-cycle request asking the surrounding interrupt logic to look at pending sources again. A command that leaves the word as it was has no visible effect at all. Priority among pending sources is left to the logic that consumes the request.

Top module: `sw_pend_reg`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `pend_o` is zero and `changed_o` and `reeval_o` are low.
- R2: A set command (`cmd_set_i`) makes `pend_o` equal to its old value ORed with `operand_i[31:0]`, visible after the clock edge that samples the command.
- R3: A clear command (`cmd_clr_i`) makes `pend_o` equal to its old value ANDed with the inverse of `operand_i[31:0]`.
- R4: A write command (`cmd_wr_i`) makes `pend_o` equal to `operand_i[31:0]`.
- R5: `operand_i[63:32]` has no effect on `pend_o`, `changed_o` or `reeval_o` for any command.
- R6: `changed_o` is high for exactly the cycle after a command whose result differs from the old value; a command that produces the same value leaves `pend_o` unchanged and both outputs low.
- R7: `reeval_o` is high in the cycle after a command only when that command changed the value and `irq_en_i` was high when the command was sampled; it is never high without `changed_o`.
- R8: When several commands are asserted in one cycle, write wins over set and set wins over clear; only the winning command is applied.
- R9: In a cycle with no command, `pend_o` holds and the next cycle shows `changed_o` and `reeval_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr_i | input | 1 | Load command (highest priority) |
| cmd_set_i | input | 1 | OR-in command |
| cmd_clr_i | input | 1 | Strip-out command (lowest priority) |
| operand_i | input | 64 | Command operand; only bits 31:0 are used |
| irq_en_i | input | 1 | Global interrupt enable, sampled with the command |
| pend_o | output | 32 | Current pending word |
| changed_o | output | 1 | One-cycle flag: last command altered the word |
| reeval_o | output | 1 | One-cycle request to re-evaluate interrupts |

## Verification
Every result is due one clock edge after the command is sampled: the new `pend_o`, `changed_o` and `reeval_o` all appear together after that edge, and the two flags drop again one edge later unless another changing command follows. The bench drives each command on a falling edge and samples all three outputs on the next falling edge, so each check lands in the single cycle where the result belongs. Pulse width is checked by an idle cycle after a changing command, and the checker compares each flag against the register's previous value and the sampled enable.

// File: rtl/sw_pend_pkg.sv
package sw_pend_pkg;

  // Command selected after priority resolution.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2,
    OP_LOAD = 2'd3
  } pend_op_e;

endpackage

// File: rtl/sw_pend_arb.sv
// Picks one command when several strobes are high: load > set > clear.
module sw_pend_arb
  import sw_pend_pkg::*;
(
  input  logic     cmd_wr_i,
  input  logic     cmd_set_i,
  input  logic     cmd_clr_i,
  output pend_op_e op_o
);

  always_comb begin
    if (cmd_wr_i)       op_o = OP_LOAD;
    else if (cmd_set_i) op_o = OP_SET;
    else if (cmd_clr_i) op_o = OP_CLR;
    else                op_o = OP_NONE;
  end

endmodule

// File: rtl/sw_pend_next.sv
// Computes the candidate word and whether it differs from the current one.
module sw_pend_next
  import sw_pend_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  pend_op_e          op_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] next_o,
  output logic              differs_o
);

  function automatic logic [DATA_W-1:0] apply_op(
    input pend_op_e          op,
    input logic [DATA_W-1:0] old,
    input logic [DATA_W-1:0] opnd
  );
    case (op)
      OP_LOAD: apply_op = opnd;
      OP_SET:  apply_op = old | opnd;
      OP_CLR:  apply_op = old & ~opnd;
      default: apply_op = old;
    endcase
  endfunction

  assign next_o    = apply_op(op_i, cur_i, opnd_i);
  assign differs_o = (next_o != cur_i);

endmodule

// File: rtl/sw_pend_store.sv
// Holds the word and the two one-cycle indications.
module sw_pend_store #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en_i,
  input  logic              irq_en_i,
  input  logic [DATA_W-1:0] next_i,
  output logic [DATA_W-1:0] val_o,
  output logic              changed_o,
  output logic              reeval_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_o     <= '0;
      changed_o <= 1'b0;
      reeval_o  <= 1'b0;
    end else begin
      if (upd_en_i) val_o <= next_i;
      changed_o <= upd_en_i;
      reeval_o  <= upd_en_i & irq_en_i;
    end
  end

endmodule

// File: rtl/sw_pend_reg.sv
module sw_pend_reg
  import sw_pend_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OPND_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr_i,
  input  logic              cmd_set_i,
  input  logic              cmd_clr_i,
  input  logic [OPND_W-1:0] operand_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] pend_o,
  output logic              changed_o,
  output logic              reeval_o
);

  localparam int HI_W = OPND_W - DATA_W;

  // Named internal events, visible to the bound checker.
  pend_op_e          sel_op;
  logic [DATA_W-1:0] opnd_lo;
  logic [DATA_W-1:0] next_val;
  logic              val_differs;
  logic              upd_en;

  assign opnd_lo = operand_i[DATA_W-1:0];

  // Upper operand bits are discarded by design.
  generate
    if (HI_W > 0) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^operand_i[OPND_W-1:DATA_W];
    end
  endgenerate

  sw_pend_arb u_arb (
    .cmd_wr_i  (cmd_wr_i),
    .cmd_set_i (cmd_set_i),
    .cmd_clr_i (cmd_clr_i),
    .op_o      (sel_op)
  );

  sw_pend_next #(.DATA_W(DATA_W)) u_next (
    .op_i      (sel_op),
    .cur_i     (pend_o),
    .opnd_i    (opnd_lo),
    .next_o    (next_val),
    .differs_o (val_differs)
  );

  assign upd_en = (sel_op != OP_NONE) && val_differs;

  sw_pend_store #(.DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en_i  (upd_en),
    .irq_en_i  (irq_en_i),
    .next_i    (next_val),
    .val_o     (pend_o),
    .changed_o (changed_o),
    .reeval_o  (reeval_o)
  );

endmodule

// File: rtl/sw_pend_chk.sv
module sw_pend_chk #(
  parameter int DATA_W = 32,
  parameter int OPND_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr_i,
  input logic              cmd_set_i,
  input logic              cmd_clr_i,
  input logic [OPND_W-1:0] operand_i,
  input logic              irq_en_i,
  input logic [DATA_W-1:0] pend_o,
  input logic              changed_o,
  input logic              reeval_o,
  input logic              upd_en
);

  // High once at least one clock edge has run out of reset.
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  logic any_cmd;
  assign any_cmd = cmd_wr_i | cmd_set_i | cmd_clr_i;

  // R1: flags low in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!changed_o && !reeval_o));

  // R4, R5
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(cmd_wr_i) |-> pend_o == $past(operand_i[DATA_W-1:0]));

  // R2, R8
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(cmd_set_i && !cmd_wr_i)
      |-> pend_o == ($past(pend_o) | $past(operand_i[DATA_W-1:0])));

  // R3, R8
  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(cmd_clr_i && !cmd_set_i && !cmd_wr_i)
      |-> pend_o == ($past(pend_o) & ~$past(operand_i[DATA_W-1:0])));

  // R6: flag means the word moved, no flag means it held
  p_changed_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && changed_o |-> pend_o != $past(pend_o));
  p_nochange_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !changed_o |-> $stable(pend_o));

  // R7
  p_reeval_needs_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reeval_o |-> changed_o);
  p_reeval_follows_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && changed_o |-> reeval_o == $past(irq_en_i));

  // R9
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(any_cmd) |-> !changed_o);

  // R6: internal update only when a command is present
  p_upd_needs_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> any_cmd);

endmodule

bind sw_pend_reg sw_pend_chk #(.DATA_W(DATA_W), .OPND_W(OPND_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr_i  (cmd_wr_i),
  .cmd_set_i (cmd_set_i),
  .cmd_clr_i (cmd_clr_i),
  .operand_i (operand_i),
  .irq_en_i  (irq_en_i),
  .pend_o    (pend_o),
  .changed_o (changed_o),
  .reeval_o  (reeval_o),
  .upd_en    (upd_en)
);

// File: tb/test_sw_pend_reg.sv
`timescale 1ns/1ps
module test_sw_pend_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr_i = 1'b0;
  logic        cmd_set_i = 1'b0;
  logic        cmd_clr_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        irq_en_i = 1'b0;
  logic [31:0] pend_o;
  logic        changed_o;
  logic        reeval_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sw_pend_reg i_sw_pend_reg (
    .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr_i), .cmd_set_i(cmd_set_i),
    .cmd_clr_i(cmd_clr_i), .operand_i(operand_i), .irq_en_i(irq_en_i),
    .pend_o(pend_o), .changed_o(changed_o), .reeval_o(reeval_o)
  );

  // Vector: {wr, set, clr, en, operand[63:0], exp_pend[31:0], exp_chg, exp_re}
  localparam int NV = 10;
  localparam logic [101:0] VEC [NV] = '{
    {4'b0101, 64'hFFFF_0000_0000_00F0, 32'h0000_00F0, 2'b11}, // R2 R5
    {4'b0101, 64'h0000_0000_0000_0030, 32'h0000_00F0, 2'b00}, // R6 same value
    {4'b0010, 64'h0000_0000_0000_0010, 32'h0000_00E0, 2'b10}, // R3 R7 enable low
    {4'b1001, 64'hABCD_0000_1234_5678, 32'h1234_5678, 2'b11}, // R4 R5
    {4'b1001, 64'h0000_0000_1234_5678, 32'h1234_5678, 2'b00}, // R6 same load
    {4'b0011, 64'hFFFF_FFFF_0000_0000, 32'h1234_5678, 2'b00}, // R5 upper ignored
    {4'b0001, 64'hFFFF_FFFF_FFFF_FFFF, 32'h1234_5678, 2'b00}, // R9 idle
    {4'b1111, 64'h0000_0000_0000_000F, 32'h0000_000F, 2'b11}, // R8 load wins
    {4'b0111, 64'h0000_0000_0000_00F0, 32'h0000_00FF, 2'b11}, // R8 set beats clear
    {4'b0011, 64'h0000_0000_0000_00FF, 32'h0000_0000, 2'b11}  // R3 to zero
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, clear inputs.
  task automatic step(input logic wr, input logic st, input logic cl,
                      input logic en, input logic [63:0] op);
    cmd_wr_i = wr; cmd_set_i = st; cmd_clr_i = cl; irq_en_i = en; operand_i = op;
    @(negedge clk);
    cmd_wr_i = 1'b0; cmd_set_i = 1'b0; cmd_clr_i = 1'b0; irq_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pend in reset", pend_o, 32'h0);
    chk("R1 flags in reset", {30'h0, changed_o, reeval_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pend after reset", pend_o, 32'h0);
    chk("R1 flags after reset", {30'h0, changed_o, reeval_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [101:0] v;
      v = VEC[i];
      step(v[101], v[100], v[99], v[98], v[97:34]);
      chk($sformatf("R2-table vec%0d pend (R3 R4 R5 R8)", i), pend_o, v[33:2]);
      chk($sformatf("R6 vec%0d changed", i), {31'h0, changed_o}, {31'h0, v[1]});
      chk($sformatf("R7 vec%0d reeval", i), {31'h0, reeval_o}, {31'h0, v[0]});
    end

    // R6: pulse lasts one cycle
    step(1'b1, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0A0A);
    chk("R6 pulse high", {30'h0, changed_o, reeval_o}, 32'h3);
    step(1'b0, 1'b0, 1'b0, 1'b1, 64'h0);
    chk("R6 pulse drops", {30'h0, changed_o, reeval_o}, 32'h0);
    chk("R9 hold after idle", pend_o, 32'h0000_0A0A);

    // R7: enable sampled with the command, not afterwards
    cmd_set_i = 1'b1; operand_i = 64'h1; irq_en_i = 1'b0;
    @(negedge clk);
    cmd_set_i = 1'b0; irq_en_i = 1'b1;
    chk("R7 late enable no reeval", {30'h0, changed_o, reeval_o}, 32'h2);
    irq_en_i = 1'b0;

    // R5: clear with only upper bits set leaves word intact
    step(1'b0, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0000);
    chk("R5 clear upper only", pend_o, 32'h0000_0A0B);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset pend", pend_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule